// File: doc/BRIEF.md
# Bit-Serial Memory Read Sequencer

This block is the bus-master side of a link to a memory that has a single shared data line and three active-low strobes: chip enable, output enable and write enable. A processor-side design hands it one command, a 9-bit start address and a byte count. The block then produces every bus cycle on its own. It opens with a three-cycle reset pattern, shifts out the address one bit per write cycle, collects the data one bit per read cycle, and closes with the reset pattern again.

Each bus cycle is one strobe pulse of fixed length with chip enable low, followed by an idle gap with all strobes high. The pulse length and the gap length are parameters. The memory advances its own address, so each further byte costs only eight more read cycles. Assembled bytes leave on a valid/ready stream. When the consumer stalls, the block waits at a cycle boundary before it starts the next byte.

Top module: `bsm_host_seq`

## Requirements
- R1: After reset, all three strobes are high, the data driver is off, `busy` is low and `rd_valid` is low.
- R2: After a command is accepted, the first three bus cycles are a read, then a write carrying 0, then a read.
- R3: The next 16 bus cycles are writes carrying the 9-bit address zero-extended to 16 bits, most significant bit first, with no read cycle among them.
- R4: Next come 8·N read cycles. Byte k is the memory content at (address + k) mod 512, sampled most significant bit first one clock before output enable rises.
- R5: The last three bus cycles of a command are read, write 0, read. `busy` goes high on the clock after acceptance and stays high until the final cycle's gap has ended. While `busy` is low, chip enable stays high.
- R6: Output enable and write enable are never low together. Chip enable is low exactly while one of them is low.
- R7: The data driver is on during every write pulse and for one clock after it. It is never on during a read pulse, and it is off in the clock before output enable falls.
- R8: Every strobe pulse lasts exactly `PULSE_W` clocks. Chip enable stays high for at least `GAP_W` clocks between cycles.
- R9: `rd_valid` with `rd_data` holds until `rd_ready`. While a byte is waiting, no read cycle of the next byte starts.
- R10: A `cmd_valid` pulse while `busy` is high is ignored and does not change the running command.
- R11: `cmd_len` encodes N−1, so a value of 0 reads one byte and the largest value reads 2^`LEN_W` bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a read command (taken when `busy` is low) |
| cmd_addr | input | CMD_AW | Start byte address |
| cmd_len | input | LEN_W | Byte count minus one |
| busy | output | 1 | Command in progress |
| rd_data | output | BYTE_W | Assembled byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 1 | Data bit driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for the data line |
| mem_dq_i | input | 1 | Data bit read from the line |

## Verification
The bench builds the block with `PULSE_W`=3, `GAP_W`=2 and `LEN_W`=3. A three-clock pulse puts the sampling clock strictly inside the pulse, so a sample taken off by one clock returns the wrong bit. The small length field makes the largest command of eight bytes cheap, and from address 0x1FF that command crosses the wrap to 0. A behavioural responder in the bench decodes the address from the write cycles and serves a computed memory pattern, so every byte can be checked against an independent value.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_OPEN,
    SQ_ADDR,
    SQ_DATA,
    SQ_CLOSE,
    SQ_DRAIN
  } sq_state_e;

  typedef enum logic [1:0] {
    CY_IDLE,
    CY_PULSE,
    CY_GAP
  } cy_state_e;

  // bus cycle positions inside the three-cycle reset pattern
  localparam int unsigned RST_PAT_LEN = 3;
  localparam int unsigned RST_PAT_WR  = 1;

endpackage

// File: rtl/bsm_cycle_engine.sv
module bsm_cycle_engine
  import bsm_pkg::*;
#(
  parameter int unsigned PULSE_W = 3,
  parameter int unsigned GAP_W   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_wr,
  input  logic req_bit,
  input  logic req_cap,
  output logic idle,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_o,
  output logic dq_oe,
  input  logic dq_i,
  output logic bit_valid,
  output logic bit_val
);

  localparam int unsigned CNT_MAX = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_W - 1);
  localparam logic [CNT_W-1:0] SAMPLE_AT  = CNT_W'(PULSE_W - 2);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_W - 1);

  cy_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             cap_q;

  assign idle = (st == CY_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CY_IDLE;
      cnt       <= '0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_o      <= 1'b0;
      dq_oe     <= 1'b0;
      cap_q     <= 1'b0;
      bit_valid <= 1'b0;
      bit_val   <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      unique case (st)
        CY_IDLE: begin
          if (req) begin
            st    <= CY_PULSE;
            cnt   <= '0;
            ce_n  <= 1'b0;
            we_n  <= ~req_wr;
            oe_n  <= req_wr;
            dq_oe <= req_wr;
            dq_o  <= req_wr & req_bit;
            cap_q <= req_cap & ~req_wr;
          end
        end
        CY_PULSE: begin
          if (cap_q && cnt == SAMPLE_AT) begin
            bit_valid <= 1'b1;
            bit_val   <= dq_i;
          end
          if (cnt == PULSE_LAST) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            we_n <= 1'b1;
            st   <= CY_GAP;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CY_GAP: begin
          dq_oe <= 1'b0;
          dq_o  <= 1'b0;
          if (cnt == GAP_LAST) begin
            st  <= CY_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= CY_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsm_rx_shift.sv
module bsm_rx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_val,
  output logic              rx_idle,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready
);

  localparam int unsigned BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh;
  logic [BC_W-1:0]   bc;

  assign rx_idle = (bc == '0) && !rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      bc       <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (bit_valid) begin
        sh <= {sh[BYTE_W-2:0], bit_val};
        if (bc == BC_LAST) begin
          bc       <= '0;
          rd_data  <= {sh[BYTE_W-2:0], bit_val};
          rd_valid <= 1'b1;
        end else begin
          bc <= bc + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bsm_seq_ctrl.sv
module bsm_seq_ctrl
  import bsm_pkg::*;
#(
  parameter int unsigned CMD_AW   = 9,
  parameter int unsigned SHIFT_AW = 16,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  input  logic             eng_idle,
  input  logic             rx_idle,
  output logic             req,
  output logic             req_wr,
  output logic             req_bit,
  output logic             req_cap
);

  localparam int unsigned STEP_MAX = (SHIFT_AW > BYTE_W) ? SHIFT_AW : BYTE_W;
  localparam int unsigned STEP_W   = $clog2(STEP_MAX);
  localparam logic [STEP_W-1:0] ADDR_LAST = STEP_W'(SHIFT_AW - 1);
  localparam logic [STEP_W-1:0] BIT_LAST  = STEP_W'(BYTE_W - 1);
  localparam logic [STEP_W-1:0] PAT_LAST  = STEP_W'(RST_PAT_LEN - 1);
  localparam logic [STEP_W-1:0] PAT_WR    = STEP_W'(RST_PAT_WR);

  sq_state_e           st;
  logic [STEP_W-1:0]   step;
  logic [LEN_W-1:0]    left;
  logic [SHIFT_AW-1:0] addr_sh;
  logic                fire;

  assign busy = (st != SQ_IDLE);

  always_comb begin
    req     = 1'b0;
    req_wr  = 1'b0;
    req_bit = 1'b0;
    req_cap = 1'b0;
    unique case (st)
      SQ_OPEN, SQ_CLOSE: begin
        req    = 1'b1;
        req_wr = (step == PAT_WR);
      end
      SQ_ADDR: begin
        req     = 1'b1;
        req_wr  = 1'b1;
        req_bit = addr_sh[SHIFT_AW-1];
      end
      SQ_DATA: begin
        req     = (step != '0) || rx_idle;
        req_cap = 1'b1;
      end
      default: ;
    endcase
  end

  assign fire = req && eng_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      step    <= '0;
      left    <= '0;
      addr_sh <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (cmd_valid) begin
            addr_sh <= {{(SHIFT_AW-CMD_AW){1'b0}}, cmd_addr};
            left    <= cmd_len;
            step    <= '0;
            st      <= SQ_OPEN;
          end
        end
        SQ_OPEN: if (fire) begin
          if (step == PAT_LAST) begin
            step <= '0;
            st   <= SQ_ADDR;
          end else step <= step + 1'b1;
        end
        SQ_ADDR: if (fire) begin
          addr_sh <= {addr_sh[SHIFT_AW-2:0], 1'b0};
          if (step == ADDR_LAST) begin
            step <= '0;
            st   <= SQ_DATA;
          end else step <= step + 1'b1;
        end
        SQ_DATA: if (fire) begin
          if (step == BIT_LAST) begin
            step <= '0;
            if (left == '0) st <= SQ_CLOSE;
            else left <= left - 1'b1;
          end else step <= step + 1'b1;
        end
        SQ_CLOSE: if (fire) begin
          if (step == PAT_LAST) begin
            step <= '0;
            st   <= SQ_DRAIN;
          end else step <= step + 1'b1;
        end
        SQ_DRAIN: if (eng_idle) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsm_host_seq.sv
module bsm_host_seq #(
  parameter int unsigned CMD_AW   = 9,
  parameter int unsigned SHIFT_AW = 16,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PULSE_W  = 2,
  parameter int unsigned GAP_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              busy,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_o,
  output logic              mem_dq_oe,
  input  logic              mem_dq_i
);

  logic eng_idle, rx_idle;
  logic req, req_wr, req_bit, req_cap;
  logic bit_valid, bit_val;

  bsm_seq_ctrl #(
    .CMD_AW(CMD_AW), .SHIFT_AW(SHIFT_AW), .LEN_W(LEN_W), .BYTE_W(BYTE_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .busy(busy), .eng_idle(eng_idle), .rx_idle(rx_idle),
    .req(req), .req_wr(req_wr), .req_bit(req_bit), .req_cap(req_cap)
  );

  bsm_cycle_engine #(
    .PULSE_W(PULSE_W), .GAP_W(GAP_W)
  ) eng_i (
    .clk(clk), .rst(rst),
    .req(req), .req_wr(req_wr), .req_bit(req_bit), .req_cap(req_cap),
    .idle(eng_idle),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dq_o(mem_dq_o), .dq_oe(mem_dq_oe), .dq_i(mem_dq_i),
    .bit_valid(bit_valid), .bit_val(bit_val)
  );

  bsm_rx_shift #(
    .BYTE_W(BYTE_W)
  ) rx_i (
    .clk(clk), .rst(rst),
    .bit_valid(bit_valid), .bit_val(bit_val),
    .rx_idle(rx_idle),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
  );

endmodule

// File: rtl/bsm_host_seq_chk.sv
module bsm_host_seq_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic [BYTE_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R6
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n); // R6
  AST_CE_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (!mem_oe_n || !mem_we_n)); // R6
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe); // R7
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe); // R7
  AST_RELEASE_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid)); // R10
  AST_BUS_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_ce_n); // R5

endmodule

bind bsm_host_seq bsm_host_seq_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/bsm_host_seq_tb_top.sv
`timescale 1ns/1ps
module bsm_host_seq_tb_top;

  localparam int PULSE_W = 3;
  localparam int GAP_W   = 2;
  localparam int LEN_W   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic       busy;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic       mem_ce_n, mem_oe_n, mem_we_n, mem_dq_o, mem_dq_oe;
  logic       resp = 1'b1;

  always #10 clk = ~clk;

  bsm_host_seq #(
    .LEN_W(LEN_W), .PULSE_W(PULSE_W), .GAP_W(GAP_W)
  ) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(resp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input int unsigned a);
    logic [31:0] t;
    t = (a * 29) ^ (a >> 4) ^ 32'h5A;
    return t[7:0];
  endfunction

  // bus monitor and behavioural responder
  bit   lg_k [0:4095];
  bit   lg_b [0:4095];
  int   lg_n = 0;
  int   viol = 0;
  logic prev_oe = 1'b1, prev_we = 1'b1, prev_strobe = 1'b0;
  int   plen = 0, gap = 0;
  bit   seen_cycle = 1'b0;
  logic [15:0] addr_sr = '0;
  int   wr_run = 0;
  bit   dmode = 1'b0;
  int   cur = 0, bidx = 0;

  always @(negedge clk) begin
    if (!rst) begin
      logic strobe;
      logic [7:0] v;
      strobe = !mem_oe_n || !mem_we_n;
      if (!mem_oe_n && !mem_we_n) viol++;
      if (mem_ce_n == strobe) viol++;
      if (!mem_oe_n && mem_dq_oe) viol++;
      if (strobe && !prev_strobe) begin
        if (seen_cycle && gap < GAP_W) viol++;
        seen_cycle = 1'b1;
        plen = 0;
      end
      if (strobe) plen++;
      else if (prev_strobe) begin
        if (plen != PULSE_W) viol++;
        gap = 0;
      end
      if (!strobe) gap++;
      if (!mem_we_n && prev_we) begin
        if (!mem_dq_oe) viol++;
        addr_sr = {addr_sr[14:0], mem_dq_o};
        wr_run++;
        lg_k[lg_n] = 1'b1; lg_b[lg_n] = mem_dq_o; lg_n++;
      end
      if (!mem_oe_n && prev_oe) begin
        if (wr_run == 16) begin
          dmode = 1'b1; cur = int'(addr_sr[8:0]); bidx = 0;
        end else if (wr_run > 0) dmode = 1'b0;
        wr_run = 0;
        if (dmode) begin
          v = mem_val(cur);
          resp = v[7-bidx];
          bidx++;
          if (bidx == 8) begin bidx = 0; cur = (cur + 1) % 512; end
        end else resp = 1'b1;
        lg_k[lg_n] = 1'b0; lg_b[lg_n] = 1'b0; lg_n++;
      end
      prev_oe = mem_oe_n; prev_we = mem_we_n; prev_strobe = strobe;
    end
  end

  // stream consumer
  logic [7:0] rx_bytes [0:4095];
  int  rx_n = 0;
  bit  hold = 1'b0;
  bit  rnd_ready = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      logic r;
      r = hold ? 1'b0 : (rnd_ready ? (($urandom % 4) != 0) : 1'b1);
      rd_ready = r;
      if (rd_valid && r) begin
        rx_bytes[rx_n] = rd_data;
        rx_n++;
      end
    end
  end

  task automatic run_cmd(input int a, input int len, input bit stall, input bit poke);
    int lb, rb, v0, n, nb, bad;
    lb = lg_n; rb = rx_n; v0 = viol; nb = len + 1;
    hold = stall;
    @(negedge clk);
    cmd_addr = 9'(a); cmd_len = LEN_W'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R5 busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      cmd_addr = 9'(a ^ 'h155); cmd_len = LEN_W'(len ^ 1); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    if (stall) begin
      repeat (300) @(negedge clk);
      chk("R9 byte held", int'(rd_valid), 1);
      chk("R9 held data", int'(rd_data), int'(mem_val(a % 512)));
      chk("R9 no next byte read while stalled", lg_n - lb, 3 + 16 + 8);
      hold = 1'b0;
    end
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    for (int i = 0; i < 5000 && (rx_n - rb) < nb; i++) @(negedge clk);
    n = lg_n - lb;
    chk("R11 cycle count", n, 3 + 16 + 8 * nb + 3);
    chk("R4 byte count", rx_n - rb, nb);
    bad = 0;
    if (lg_k[lb] != 0 || lg_k[lb+1] != 1 || lg_b[lb+1] != 0 || lg_k[lb+2] != 0) bad++;
    chk("R2 opening pattern", bad, 0);
    bad = 0;
    for (int j = 0; j < 16; j++) begin
      logic [15:0] ea;
      ea = {7'b0, 9'(a)};
      if (lg_k[lb+3+j] != 1 || lg_b[lb+3+j] != ea[15-j]) bad++;
    end
    chk("R3 address bits", bad, 0);
    bad = 0;
    for (int j = 0; j < 8 * nb; j++) if (lg_k[lb+19+j] != 0) bad++;
    chk("R4 data cycles are reads", bad, 0);
    bad = 0;
    if (n >= 3) begin
      if (lg_k[lb+n-3] != 0 || lg_k[lb+n-2] != 1 || lg_b[lb+n-2] != 0 || lg_k[lb+n-1] != 0) bad++;
    end else bad++;
    chk("R5 closing pattern", bad, 0);
    for (int k = 0; k < nb && k < (rx_n - rb); k++)
      chk("R4 byte value", int'(rx_bytes[rb+k]), int'(mem_val((a + k) % 512)));
    chk("R6 R7 R8 strobe timing faults", viol - v0, 0);
    chk("R5 busy low at end", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ce_n", int'(mem_ce_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 dq_oe", int'(mem_dq_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    run_cmd(0, 0, 1'b0, 1'b0);        // single byte, R11 minimum
    run_cmd('h1FF, 7, 1'b0, 1'b0);    // wrap past top, largest length
    run_cmd('h1FE, 2, 1'b1, 1'b0);    // consumer stall, R9
    run_cmd('h0A5, 3, 1'b0, 1'b1);    // command during busy, R10
    rnd_ready = 1'b1;
    for (int t = 0; t < 10; t++)
      run_cmd(int'($urandom % 512), int'($urandom % 8), 1'b0, (t % 3) == 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule